// File: doc/BRIEF.md
# TFT Panel Sync Timing Generator

This block produces the raster timing for a TFT display panel from a fast system clock. A programmable divider derives the pixel clock and a one-cycle pixel strobe. Two segment sequencers, one counting pixels and one counting lines, step through four segments in a fixed order: sync pulse, back porch, visible region and front porch. The length of each segment is a separate input field. From the two sequencers the block drives horizontal sync, vertical sync, a data-valid flag and a one-pixel line-end pulse. Each of these, and the pixel clock waveform, has its own polarity inversion input.

For status, the block reports the current horizontal and vertical segment as 2-bit codes. It also reports a line counter that counts down through the visible lines of each frame. A single video enable input gates the whole block. When it is low, every timing output is held low and both sequencers wait at the start of a frame. When it goes high again, scanning restarts from the first pixel of the first sync line.

Top module: `tft_sync_gen`

## Requirements
- R1: With divider value D, `pix_stb` pulses for one system clock once every 2*(D+1) system clocks. `pix_clk` (not inverted) is low for the first D+1 of those clocks and high for the last D+1.
- R2: Each line consists of hsync_len+1 sync pixels, hback_len+1 back-porch pixels, hshow_len+1 visible pixels and hfront_len+1 front-porch pixels, in that order. `h_seg` reads 00 during sync, 01 during back porch, 10 while visible and 11 during front porch.
- R3: Each frame consists of vsync_len+1, vback_len+1, vshow_len+1 and vfront_len+1 lines in the same segment order. `v_seg` uses the same four codes as `h_seg`.
- R4: Before inversion, `hsync` is high exactly during horizontal sync pixels and `vsync` is high exactly during vertical sync lines.
- R5: Before inversion, `data_valid` is high only for pixels where both `h_seg` and `v_seg` read 10.
- R6: `line_left` holds vshow_len during vertical sync and back porch. It reads vshow_len-k during visible line k (counting from 0), holds 0 through the front porch, and never rises except on entry to vertical sync.
- R7: When `lend_on` is 1, `line_end` (before inversion) is high for exactly the first front-porch pixel of every line. When `lend_on` is 0, `line_end` stays 0 whatever `inv_lend` is set to.
- R8: Setting `inv_hsync`, `inv_vsync`, `inv_dv`, `inv_lend` or `inv_pclk` to 1 inverts the corresponding output while video is enabled.
- R9: While `video_on` is 0, all of these outputs read 0: `pix_stb`, `pix_clk`, `hsync`, `vsync`, `data_valid`, `line_end`, `h_seg` and `v_seg`. `line_left` reads vshow_len from the second clock onward. When video is enabled again, scanning restarts at the first sync pixel of the first sync line.
- R10: A field of value 0 still gives a segment of one pixel or one line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| video_on | input | 1 | Master enable for all timing outputs |
| pclk_div | input | 10 | Pixel clock divider value D |
| hsync_len | input | 8 | Horizontal sync width minus one, in pixels |
| hback_len | input | 8 | Horizontal back porch minus one, in pixels |
| hshow_len | input | 11 | Visible pixels per line minus one |
| hfront_len | input | 8 | Horizontal front porch minus one, in pixels |
| vsync_len | input | 8 | Vertical sync width minus one, in lines |
| vback_len | input | 8 | Vertical back porch minus one, in lines |
| vshow_len | input | 10 | Visible lines per frame minus one |
| vfront_len | input | 8 | Vertical front porch minus one, in lines |
| inv_hsync | input | 1 | Invert horizontal sync |
| inv_vsync | input | 1 | Invert vertical sync |
| inv_dv | input | 1 | Invert data valid |
| inv_lend | input | 1 | Invert line end |
| inv_pclk | input | 1 | Invert pixel clock waveform |
| lend_on | input | 1 | Enable the line-end output |
| pix_stb | output | 1 | One-system-clock strobe at the end of each pixel |
| pix_clk | output | 1 | Pixel clock waveform |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| data_valid | output | 1 | Visible-pixel flag |
| line_end | output | 1 | One-pixel pulse at the start of the front porch |
| h_seg | output | 2 | Horizontal segment code |
| v_seg | output | 2 | Vertical segment code |
| line_left | output | 10 | Down-counting visible line counter |

## Verification
The assertions check the following on every cycle:
- Both segment codes advance only in the order 00, 01, 10, 11, 00.
- `h_seg` changes only after a pixel strobe, and the strobe never appears on two clocks in a row.
- Sync outputs agree with the segment codes, and data valid is high only inside the visible window.
- `line_left` rises only on entry to vertical sync.
- Line end stays 0 while disabled, and every output is quiet while `video_on` is low.

The bench's scenarios cover what the assertions cannot, and compare each pixel against values computed from the field settings:
- the exact segment lengths and the down-count values over whole frames;
- the strobe period for several divider values;
- where the line-end pulse falls;
- the inverted encodings;
- the restart from frame start after video is disabled partway through a frame.

// File: rtl/tft_sync_pkg.sv
package tft_sync_pkg;

  // Segment order within a line or a frame; the code is also the status value.
  typedef enum logic [1:0] {
    SEG_SYNC  = 2'b00,
    SEG_BACK  = 2'b01,
    SEG_SHOW  = 2'b10,
    SEG_FRONT = 2'b11
  } seg_e;

  function automatic seg_e seg_after(seg_e s);
    logic [1:0] raw;
    raw = s;
    raw = raw + 2'd1;
    return seg_e'(raw);
  endfunction

  // Output driver: quiet when disabled, otherwise active level xor inversion.
  function automatic logic drive_pin(logic run, logic active, logic inv);
    return run & (active ^ inv);
  endfunction

  // Number of system clocks in one pixel for a divider value.
  function automatic int unsigned pix_period(int unsigned div);
    return 2 * (div + 1);
  endfunction

endpackage

// File: rtl/tft_pclk_div.sv
module tft_pclk_div #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick,
  output logic             half_hi
);

  logic [DIV_W-1:0] cnt_q;
  logic             half_q;
  logic             at_end;

  assign at_end  = (cnt_q >= div_val);
  assign tick    = run & at_end & half_q;
  assign half_hi = half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else if (!run) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else if (at_end) begin
      cnt_q  <= '0;
      half_q <= ~half_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/tft_seg_seq.sv
module tft_seg_seq
  import tft_sync_pkg::*;
#(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          step,
  input  logic [CW-1:0] len_sync,
  input  logic [CW-1:0] len_back,
  input  logic [CW-1:0] len_show,
  input  logic [CW-1:0] len_front,
  output seg_e          seg,
  output logic [CW-1:0] cnt,
  output logic          wrap
);

  seg_e          seg_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cur_len;
  logic          at_end;

  always_comb begin
    case (seg_q)
      SEG_SYNC:  cur_len = len_sync;
      SEG_BACK:  cur_len = len_back;
      SEG_SHOW:  cur_len = len_show;
      default:   cur_len = len_front;
    endcase
  end

  assign at_end = (cnt_q >= cur_len);
  assign wrap   = step & at_end & (seg_q == SEG_FRONT);
  assign seg    = seg_q;
  assign cnt    = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q <= SEG_SYNC;
      cnt_q <= '0;
    end else if (!run) begin
      seg_q <= SEG_SYNC;
      cnt_q <= '0;
    end else if (step) begin
      if (at_end) begin
        seg_q <= seg_after(seg_q);
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/tft_line_ctr.sv
module tft_line_ctr
  import tft_sync_pkg::*;
#(
  parameter int VACT_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [VACT_W-1:0] show_len,
  input  logic              line_step,
  input  logic              frame_step,
  input  seg_e              v_seg,
  output logic [VACT_W-1:0] left
);

  logic [VACT_W-1:0] left_q;

  assign left = left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (!run || frame_step) begin
      left_q <= show_len;
    end else if (line_step && v_seg == SEG_SHOW && left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

endmodule

// File: rtl/tft_out_stage.sv
module tft_out_stage
  import tft_sync_pkg::*;
(
  input  logic       run,
  input  seg_e       h_seg_i,
  input  seg_e       v_seg_i,
  input  logic       lend_pulse,
  input  logic       half_hi,
  input  logic       pix_tick,
  input  logic       lend_on,
  input  logic       inv_hsync,
  input  logic       inv_vsync,
  input  logic       inv_dv,
  input  logic       inv_lend,
  input  logic       inv_pclk,
  output logic       pix_stb,
  output logic       pix_clk,
  output logic       hsync,
  output logic       vsync,
  output logic       data_valid,
  output logic       line_end,
  output logic [1:0] h_seg,
  output logic [1:0] v_seg
);

  logic show_both;

  assign show_both  = (h_seg_i == SEG_SHOW) && (v_seg_i == SEG_SHOW);
  assign pix_stb    = run & pix_tick;
  assign pix_clk    = drive_pin(run, half_hi, inv_pclk);
  assign hsync      = drive_pin(run, h_seg_i == SEG_SYNC, inv_hsync);
  assign vsync      = drive_pin(run, v_seg_i == SEG_SYNC, inv_vsync);
  assign data_valid = drive_pin(run, show_both, inv_dv);
  assign line_end   = drive_pin(run & lend_on, lend_pulse, inv_lend);
  assign h_seg      = run ? h_seg_i : 2'b00;
  assign v_seg      = run ? v_seg_i : 2'b00;

endmodule

// File: rtl/tft_sync_gen.sv
module tft_sync_gen
  import tft_sync_pkg::*;
#(
  parameter int DIV_W  = 10,
  parameter int HACT_W = 11,
  parameter int HPOR_W = 8,
  parameter int VACT_W = 10,
  parameter int VPOR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              video_on,
  input  logic [DIV_W-1:0]  pclk_div,
  input  logic [HPOR_W-1:0] hsync_len,
  input  logic [HPOR_W-1:0] hback_len,
  input  logic [HACT_W-1:0] hshow_len,
  input  logic [HPOR_W-1:0] hfront_len,
  input  logic [VPOR_W-1:0] vsync_len,
  input  logic [VPOR_W-1:0] vback_len,
  input  logic [VACT_W-1:0] vshow_len,
  input  logic [VPOR_W-1:0] vfront_len,
  input  logic              inv_hsync,
  input  logic              inv_vsync,
  input  logic              inv_dv,
  input  logic              inv_lend,
  input  logic              inv_pclk,
  input  logic              lend_on,
  output logic              pix_stb,
  output logic              pix_clk,
  output logic              hsync,
  output logic              vsync,
  output logic              data_valid,
  output logic              line_end,
  output logic [1:0]        h_seg,
  output logic [1:0]        v_seg,
  output logic [VACT_W-1:0] line_left
);

  localparam int HC_W = (HACT_W > HPOR_W) ? HACT_W : HPOR_W;
  localparam int VC_W = (VACT_W > VPOR_W) ? VACT_W : VPOR_W;

  // Named internal events
  logic            pix_tick;
  logic            half_hi;
  logic            line_wrap;
  logic            frame_wrap;
  logic            lend_pulse;
  seg_e            h_seg_raw;
  seg_e            v_seg_raw;
  logic [HC_W-1:0] h_cnt;
  logic [VC_W-1:0] v_cnt;

  tft_pclk_div #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (video_on),
    .div_val (pclk_div),
    .tick    (pix_tick),
    .half_hi (half_hi)
  );

  tft_seg_seq #(.CW(HC_W)) u_hseq (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (video_on),
    .step      (pix_tick),
    .len_sync  (HC_W'(hsync_len)),
    .len_back  (HC_W'(hback_len)),
    .len_show  (HC_W'(hshow_len)),
    .len_front (HC_W'(hfront_len)),
    .seg       (h_seg_raw),
    .cnt       (h_cnt),
    .wrap      (line_wrap)
  );

  tft_seg_seq #(.CW(VC_W)) u_vseq (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (video_on),
    .step      (line_wrap),
    .len_sync  (VC_W'(vsync_len)),
    .len_back  (VC_W'(vback_len)),
    .len_show  (VC_W'(vshow_len)),
    .len_front (VC_W'(vfront_len)),
    .seg       (v_seg_raw),
    .cnt       (v_cnt),
    .wrap      (frame_wrap)
  );

  assign lend_pulse = (h_seg_raw == SEG_FRONT) && (h_cnt == '0);

  tft_line_ctr #(.VACT_W(VACT_W)) u_lines (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (video_on),
    .show_len   (vshow_len),
    .line_step  (line_wrap),
    .frame_step (frame_wrap),
    .v_seg      (v_seg_raw),
    .left       (line_left)
  );

  tft_out_stage u_out (
    .run        (video_on),
    .h_seg_i    (h_seg_raw),
    .v_seg_i    (v_seg_raw),
    .lend_pulse (lend_pulse),
    .half_hi    (half_hi),
    .pix_tick   (pix_tick),
    .lend_on    (lend_on),
    .inv_hsync  (inv_hsync),
    .inv_vsync  (inv_vsync),
    .inv_dv     (inv_dv),
    .inv_lend   (inv_lend),
    .inv_pclk   (inv_pclk),
    .pix_stb    (pix_stb),
    .pix_clk    (pix_clk),
    .hsync      (hsync),
    .vsync      (vsync),
    .data_valid (data_valid),
    .line_end   (line_end),
    .h_seg      (h_seg),
    .v_seg      (v_seg)
  );

endmodule

// File: rtl/tft_sync_gen_chk.sv
module tft_sync_gen_chk #(
  parameter int VACT_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              video_on,
  input logic              inv_hsync,
  input logic              inv_vsync,
  input logic              inv_dv,
  input logic              lend_on,
  input logic              pix_stb,
  input logic              pix_clk,
  input logic              hsync,
  input logic              vsync,
  input logic              data_valid,
  input logic              line_end,
  input logic [1:0]        h_seg,
  input logic [1:0]        v_seg,
  input logic [VACT_W-1:0] line_left
);

  // R1
  stb_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_stb |=> !pix_stb);

  // R2
  hseg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (video_on && $past(video_on) && !$past(pix_stb)) |-> $stable(h_seg));

  // R2
  hseg_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (video_on && $past(video_on) && h_seg != $past(h_seg))
      |-> h_seg == 2'($past(h_seg) + 2'd1));

  // R3
  vseg_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (video_on && $past(video_on) && v_seg != $past(v_seg))
      |-> v_seg == 2'($past(v_seg) + 2'd1));

  // R4
  sync_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    video_on |-> (((hsync ^ inv_hsync) == (h_seg == 2'b00)) &&
                  ((vsync ^ inv_vsync) == (v_seg == 2'b00))));

  // R5
  dv_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (video_on && (data_valid ^ inv_dv)) |-> (h_seg == 2'b10 && v_seg == 2'b10));

  // R6
  left_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (video_on && $past(video_on) && line_left > $past(line_left)) |-> v_seg == 2'b00);

  // R7
  lend_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lend_on |-> !line_end);

  // R9
  quiet_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !video_on |-> (!pix_stb && !pix_clk && !hsync && !vsync && !data_valid &&
                   !line_end && h_seg == 2'b00 && v_seg == 2'b00));

endmodule

bind tft_sync_gen tft_sync_gen_chk #(.VACT_W(VACT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .video_on   (video_on),
  .inv_hsync  (inv_hsync),
  .inv_vsync  (inv_vsync),
  .inv_dv     (inv_dv),
  .lend_on    (lend_on),
  .pix_stb    (pix_stb),
  .pix_clk    (pix_clk),
  .hsync      (hsync),
  .vsync      (vsync),
  .data_valid (data_valid),
  .line_end   (line_end),
  .h_seg      (h_seg),
  .v_seg      (v_seg),
  .line_left  (line_left)
);

// File: tb/tft_sync_gen_test.sv
module tft_sync_gen_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        video_on = 1'b0;
  logic [9:0]  pclk_div = '0;
  logic [7:0]  hsync_len = '0, hback_len = '0, hfront_len = '0;
  logic [10:0] hshow_len = '0;
  logic [7:0]  vsync_len = '0, vback_len = '0, vfront_len = '0;
  logic [9:0]  vshow_len = '0;
  logic        inv_hsync = 0, inv_vsync = 0, inv_dv = 0, inv_lend = 0, inv_pclk = 0;
  logic        lend_on = 0;
  logic        pix_stb, pix_clk, hsync, vsync, data_valid, line_end;
  logic [1:0]  h_seg, v_seg;
  logic [9:0]  line_left;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  tft_sync_gen uut (
    .clk(clk), .rst_n(rst_n), .video_on(video_on), .pclk_div(pclk_div),
    .hsync_len(hsync_len), .hback_len(hback_len), .hshow_len(hshow_len),
    .hfront_len(hfront_len), .vsync_len(vsync_len), .vback_len(vback_len),
    .vshow_len(vshow_len), .vfront_len(vfront_len),
    .inv_hsync(inv_hsync), .inv_vsync(inv_vsync), .inv_dv(inv_dv),
    .inv_lend(inv_lend), .inv_pclk(inv_pclk), .lend_on(lend_on),
    .pix_stb(pix_stb), .pix_clk(pix_clk), .hsync(hsync), .vsync(vsync),
    .data_valid(data_valid), .line_end(line_end), .h_seg(h_seg), .v_seg(v_seg),
    .line_left(line_left)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Segment index of position p given the four field values (each value N gives N+1).
  function automatic int seg_of(int p, int a, int b, int c);
    if (p < a + 1) return 0;
    if (p < a + b + 2) return 1;
    if (p < a + b + c + 3) return 2;
    return 3;
  endfunction

  task automatic set_timing(input int d, input int hs, input int hb, input int ha,
                            input int hf, input int vs, input int vb, input int va,
                            input int vf);
    pclk_div = 10'(d);
    hsync_len = 8'(hs); hback_len = 8'(hb); hshow_len = 11'(ha); hfront_len = 8'(hf);
    vsync_len = 8'(vs); vback_len = 8'(vb); vshow_len = 10'(va); vfront_len = 8'(vf);
  endtask

  task automatic wait_stb();
    do @(negedge clk); while (!pix_stb);
  endtask

  // Enable video and compare every pixel of nframes frames against the field model.
  task automatic scan_frames(input int nframes, input string tag);
    int hs = hsync_len, hb = hback_len, ha = hshow_len, hf = hfront_len;
    int vs = vsync_len, vb = vback_len, va = vshow_len, vf = vfront_len;
    int htot = hs + hb + ha + hf + 4;
    int vtot = vs + vb + va + vf + 4;
    @(negedge clk);
    video_on = 1'b1;
    for (int p = 0; p < nframes * htot * vtot; p++) begin
      int col = p % htot;
      int row = (p / htot) % vtot;
      int hsg = seg_of(col, hs, hb, ha);
      int vsg = seg_of(row, vs, vb, va);
      logic [7:0] exp_v, act_v;
      int exp_left;
      wait_stb();
      exp_v[7:6] = 2'(hsg);
      exp_v[5:4] = 2'(vsg);
      exp_v[3] = (hsg == 0) ^ inv_hsync;
      exp_v[2] = (vsg == 0) ^ inv_vsync;
      exp_v[1] = ((hsg == 2) && (vsg == 2)) ^ inv_dv;
      exp_v[0] = lend_on ? ((col == hs + hb + ha + 3) ^ inv_lend) : 1'b0;
      act_v = {h_seg, v_seg, hsync, vsync, data_valid, line_end};
      check(act_v == exp_v, tag, "pixel segs/syncs/dv/lend", act_v, exp_v);
      if (vsg < 2) exp_left = va;
      else if (vsg == 2) exp_left = va - (row - (vs + vb + 2));
      else exp_left = 0;
      check(line_left == 10'(exp_left), "R6", "line_left", line_left, exp_left);
    end
    @(negedge clk);
    video_on = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    #1;
    check({pix_stb, pix_clk, hsync, vsync, data_valid, line_end, h_seg, v_seg} == '0,
          "R9", "outputs quiet after reset",
          {pix_stb, pix_clk, hsync, vsync, data_valid, line_end, h_seg, v_seg}, 0);
    check(line_left == vshow_len, "R9", "line_left while off", line_left, vshow_len);
  endtask

  task automatic t_pclk(input int d, input bit ip);
    int n = 0, hi = 0;
    pclk_div = 10'(d);
    inv_pclk = ip;
    @(negedge clk);
    video_on = 1'b1;
    #1;
    check(pix_clk == ip, "R8", "pix_clk level at start", pix_clk, ip);
    wait_stb();
    do begin
      @(negedge clk);
      n++;
      if (pix_clk) hi++;
    end while (!pix_stb);
    check(n == 2 * (d + 1), "R1", "strobe period", n, 2 * (d + 1));
    check(hi == d + 1, "R1", "pix_clk high clocks", hi, d + 1);
    @(negedge clk);
    video_on = 1'b0;
    #1;
    check(pix_clk == 1'b0, "R9", "pix_clk off with inversion", pix_clk, 0);
    inv_pclk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // R2 R3 R4 R5 R6 R7: base geometry, two frames so the wrap and reload are covered
  task automatic t_base();
    set_timing(1, 1, 1, 3, 1, 0, 1, 2, 0);
    lend_on = 1'b1;
    scan_frames(2, "R2");
  endtask

  // R10: every field zero
  task automatic t_zero();
    set_timing(0, 0, 0, 0, 0, 0, 0, 0, 0);
    lend_on = 1'b1;
    scan_frames(2, "R10");
  endtask

  // R8: all inversions set
  task automatic t_invert();
    set_timing(0, 2, 0, 4, 1, 1, 0, 1, 1);
    inv_hsync = 1; inv_vsync = 1; inv_dv = 1; inv_lend = 1; lend_on = 1;
    scan_frames(1, "R8");
    inv_hsync = 0; inv_vsync = 0; inv_dv = 0; inv_lend = 0;
  endtask

  // R7: line end disabled while its inversion is set
  task automatic t_lend_off();
    set_timing(0, 0, 1, 2, 2, 0, 0, 1, 0);
    lend_on = 0;
    inv_lend = 1;
    scan_frames(1, "R7");
    inv_lend = 0;
    lend_on = 1;
  endtask

  // R9: disable partway through a frame, then restart from the frame start
  task automatic t_disable_mid();
    set_timing(0, 1, 1, 3, 1, 0, 1, 2, 0);
    inv_pclk = 1'b1;
    @(negedge clk);
    video_on = 1'b1;
    repeat (25) wait_stb();
    @(negedge clk);
    video_on = 1'b0;
    #1;
    check({pix_stb, pix_clk, hsync, vsync, data_valid, line_end, h_seg, v_seg} == '0,
          "R9", "outputs quiet at disable",
          {pix_stb, pix_clk, hsync, vsync, data_valid, line_end, h_seg, v_seg}, 0);
    repeat (2) @(negedge clk);
    check(line_left == vshow_len, "R9", "line_left reloaded", line_left, vshow_len);
    inv_pclk = 1'b0;
    scan_frames(1, "R9");
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    set_timing(0, 1, 1, 3, 1, 0, 1, 2, 0);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_pclk(0, 1'b0);
    t_pclk(3, 1'b0);
    t_pclk(2, 1'b1);
    t_base();
    t_zero();
    t_invert();
    t_lend_off();
    t_disable_mid();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule